// File: doc/BRIEF.md
# Programmable Comma Word Aligner

This block frames the receive side of a serial link that carries 10-bit code groups. A deserializer hands it one unframed 10-bit word per clock. The block looks for one of two programmable comma patterns in that stream. Each comparison uses only the bit positions that a programmable mask selects. When a comma is found, the block moves its word boundary so that each later output word is a whole code group.

Two alignment policies are available. In barrel mode the boundary jumps in one step to the offset where the comma was found. In bit-slip mode the boundary moves one bit at a time, and after each move there is a short quiet period before the next comparison. A one-shot policy fixes the boundary at the first comma. A continuous policy realigns whenever a comma shows up at a different offset.

The block also has an input inversion control and a bypass. It reports the current offset and an aligned flag. All configuration inputs are static register values and should only change while reset is asserted; the bypass control is the one exception. A configuration register that feeds the block is expected to reset to a mask of 10'h3FF, comma A 10'h183 and comma B 10'h27C. These values are exported by the package.

Top module: `comma_word_aligner`

## Requirements
- R1: While `rst_n` is low, `frame_word`, `align_offset` and `aligned` are all zero.
- R2: Bit 0 of each input word is the earliest bit received. The search window is {current word, previous word}, so window bit j for j < 10 comes from the previous word. The candidate at offset k is window bits k+9..k. A candidate matches when it equals `cfg_comma_a` or `cfg_comma_b` in every bit position where `cfg_mask` is 1. Bits where the mask is 0 do not take part.
- R3: When several offsets match in the same window, the lowest offset is taken.
- R4: In barrel mode (`cfg_slip`=0), an accepted match at offset k sets `align_offset` to k on the next edge. On that same edge, `frame_word` shows the matched candidate. In every other cycle, `frame_word` is the candidate at the offset in force. A word presented before edge n reaches `frame_word` after edge n+2 at offset 0.
- R5: In bit-slip mode (`cfg_slip`=1), a match at an offset other than the current one advances `align_offset` by one, wrapping from 9 to 0. The four windows that follow are not examined. A match at the current offset locks the boundary.
- R6: With `cfg_continuous`=0, once the boundary is locked, later commas at any offset leave `align_offset` unchanged.
- R7: With `cfg_continuous`=1, a comma at an offset other than the locked one causes realignment to that comma.
- R8: `aligned` rises on the edge after the one at which the first framed comma appears on `frame_word`. It clears on reset and on every realignment or slip.
- R9: While `cfg_bypass`=1, no search takes place and `align_offset` holds its value. `aligned` is driven low. `frame_word` carries the previous word with no shift, which is the offset-0 candidate.
- R10: With `cfg_invert`=1, every input bit is inverted before the search and before output. A comma sent inverted is therefore found, and it appears on `frame_word` in true polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_word | input | 10 | Unframed word from the deserializer |
| cfg_slip | input | 1 | 1 = bit-slip alignment, 0 = barrel alignment |
| cfg_continuous | input | 1 | 1 = realign on any comma at a new offset |
| cfg_bypass | input | 1 | 1 = pass words through unaligned |
| cfg_invert | input | 1 | 1 = invert every received bit |
| cfg_mask | input | 10 | Compare mask, 1 = bit takes part |
| cfg_comma_a | input | 10 | Comma pattern A |
| cfg_comma_b | input | 10 | Comma pattern B |
| frame_word | output | 10 | Framed code group |
| align_offset | output | 4 | Current boundary offset, 0 to 9 |
| aligned | output | 1 | Boundary established and framed comma seen |

## Verification
The bench targets these corner cases:
- Overlapping matches in one window, under a narrow mask. A wrong priority encoder lands on offset 5 instead of 1.
- A comma that differs from pattern A only in a masked-off bit. It must be found, and the same word must be ignored once the mask is full.
- The holdoff after a slip. It is measured as an exact five-edge gap, which exposes an off-by-one in the counter.
- One-shot against continuous policy, when the comma offset moves. Sticky alignment must hold in one case and follow in the other.
- Inversion and bypass latency, where a design that tapped the wrong register would be one word early or late.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

   // Recommended reset values for the configuration register feeding the block
   localparam logic [9:0] CWA_DEF_MASK    = 10'h3FF;
   localparam logic [9:0] CWA_DEF_COMMA_A = 10'h183;
   localparam logic [9:0] CWA_DEF_COMMA_B = 10'h27C;

   typedef enum logic {
      ALIGN_BARREL = 1'b0,
      ALIGN_SLIP   = 1'b1
   } align_mode_e;

   typedef struct packed {
      align_mode_e mode;
      logic        cont;
      logic        bypass;
   } cwa_ctl_t;

endpackage

// File: rtl/cwa_window.sv
// Input conditioning and two-word search window.
module cwa_window #(
   parameter int W = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   raw_i,
   input  logic           invert_i,
   output logic [2*W-1:0] win_o
);
   logic [W-1:0] cur_q;
   logic [W-1:0] prev_q;
   logic [W-1:0] cond;

   assign cond = raw_i ^ {W{invert_i}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         cur_q  <= cond;
         prev_q <= cur_q;
      end
   end

   // earliest bit at index 0: previous word occupies the low half
   assign win_o = {cur_q, prev_q};

endmodule

// File: rtl/cwa_detect.sv
// Masked comparison at every offset and lowest-offset priority selection.
module cwa_detect #(
   parameter int W    = 10,
   parameter int OFFW = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*W-1:0]      win_i,
   input  logic [W-1:0]        mask_i,
   input  logic [W-1:0]        comma_a_i,
   input  logic [W-1:0]        comma_b_i,
   output logic [W-1:0][W-1:0] cand_o,
   output logic [W-1:0]        hit_o,
   output logic                found_o,
   output logic [OFFW-1:0]     pos_o
);
   for (genvar k = 0; k < W; k++) begin : g_off
      logic match_a;
      logic match_b;
      assign cand_o[k] = win_i[k +: W];
      assign match_a   = ((cand_o[k] ^ comma_a_i) & mask_i) == '0;
      assign match_b   = ((cand_o[k] ^ comma_b_i) & mask_i) == '0;
      assign hit_o[k]  = match_a | match_b;
   end

   always_comb begin
      pos_o = '0;
      for (int k = W - 1; k >= 0; k--) begin
         if (hit_o[k]) pos_o = OFFW'(k);
      end
   end

   assign found_o = |hit_o;

   // R3
   lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> (hit_o[pos_o] && ((hit_o & ((W'(1) << pos_o) - W'(1))) == '0)));

endmodule

// File: rtl/cwa_ctrl.sv
// Boundary state: offset, lock, slip holdoff and aligned flag.
module cwa_ctrl
   import cwa_pkg::*;
#(
   parameter int W       = 10,
   parameter int OFFW    = 4,
   parameter int HOLDOFF = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  cwa_ctl_t        ctl_i,
   input  logic            found_i,
   input  logic [OFFW-1:0] pos_i,
   output logic [OFFW-1:0] off_o,
   output logic [OFFW-1:0] off_next_o,
   output logic            aligned_o
);
   localparam int HW = $clog2(HOLDOFF + 1);
   localparam logic [OFFW-1:0] LAST_OFF = OFFW'(W - 1);

   logic [OFFW-1:0] off_q, off_n;
   logic [HW-1:0]   hold_q, hold_n;
   logic            locked_q, locked_n;
   logic            pend_q, pend_n;
   logic            aligned_q, aligned_n;
   logic            accept;
   logic [OFFW-1:0] off_inc;

   assign off_inc = (off_q == LAST_OFF) ? '0 : off_q + OFFW'(1);

   always_comb begin
      off_n     = off_q;
      locked_n  = locked_q;
      hold_n    = (hold_q != '0) ? hold_q - HW'(1) : '0;
      pend_n    = 1'b0;
      aligned_n = aligned_q | pend_q;
      accept    = 1'b0;
      if (ctl_i.bypass) begin
         aligned_n = 1'b0;
      end else if (hold_q == '0 && found_i) begin
         accept = !locked_q || (ctl_i.cont && pos_i != off_q);
         if (accept) begin
            aligned_n = 1'b0;
            if (ctl_i.mode == ALIGN_SLIP && pos_i != off_q) begin
               off_n    = off_inc;
               locked_n = 1'b0;
               hold_n   = HW'(HOLDOFF);
            end else begin
               off_n    = pos_i;
               locked_n = 1'b1;
               pend_n   = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q     <= '0;
         hold_q    <= '0;
         locked_q  <= 1'b0;
         pend_q    <= 1'b0;
         aligned_q <= 1'b0;
      end else begin
         off_q     <= off_n;
         hold_q    <= hold_n;
         locked_q  <= locked_n;
         pend_q    <= pend_n;
         aligned_q <= aligned_n;
      end
   end

   assign off_o      = off_q;
   assign off_next_o = off_n;
   assign aligned_o  = aligned_q;

   // R5
   slip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctl_i.mode) == ALIGN_SLIP && off_q != $past(off_q))
      |-> (off_q == (($past(off_q) == LAST_OFF) ? '0 : $past(off_q) + OFFW'(1))));

   // R5
   holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q != '0) |=> (off_q == $past(off_q)));

   // R6
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_i.cont && locked_q) |=> (off_q == $past(off_q)));

   // R8
   aligned_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aligned_q |-> locked_q);

   // R9
   bypass_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i.bypass |=> (!aligned_q && off_q == $past(off_q)));

   // R4
   offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_q <= LAST_OFF);

endmodule

// File: rtl/cwa_frame.sv
// Output register: selects the candidate at the offset taking effect.
module cwa_frame #(
   parameter int W    = 10,
   parameter int OFFW = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [W-1:0][W-1:0] cand_i,
   input  logic [OFFW-1:0]     sel_i,
   input  logic                bypass_i,
   output logic [W-1:0]        word_o
);
   logic [W-1:0] pick;
   logic [W-1:0] word_q;

   always_comb begin
      pick = cand_i[0];
      if (!bypass_i) begin
         for (int k = 0; k < W; k++) begin
            if (sel_i == OFFW'(k)) pick = cand_i[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= pick;
   end

   assign word_o = word_q;

   // R9
   bypass_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_i |=> (word_q == $past(cand_i[0])));

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
   import cwa_pkg::*;
#(
   parameter int W       = 10,
   parameter int OFFW    = 4,
   parameter int HOLDOFF = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W-1:0]    raw_word,
   input  logic            cfg_slip,
   input  logic            cfg_continuous,
   input  logic            cfg_bypass,
   input  logic            cfg_invert,
   input  logic [W-1:0]    cfg_mask,
   input  logic [W-1:0]    cfg_comma_a,
   input  logic [W-1:0]    cfg_comma_b,
   output logic [W-1:0]    frame_word,
   output logic [OFFW-1:0] align_offset,
   output logic            aligned
);
   if (W < 2) begin : g_bad_width
      $error("comma_word_aligner: W must be at least 2");
   end
   if ((1 << OFFW) < W) begin : g_bad_offw
      $error("comma_word_aligner: OFFW too narrow for W offsets");
   end
   if (HOLDOFF < 1) begin : g_bad_hold
      $error("comma_word_aligner: HOLDOFF must be at least 1");
   end

   logic [2*W-1:0]      win;
   logic [W-1:0][W-1:0] cand;
   logic [W-1:0]        hit;
   logic                found;
   logic [OFFW-1:0]     pos;
   logic [OFFW-1:0]     off_next;
   cwa_ctl_t            ctl;

   assign ctl.mode   = align_mode_e'(cfg_slip);
   assign ctl.cont   = cfg_continuous;
   assign ctl.bypass = cfg_bypass;

   cwa_window #(.W(W)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_i    (raw_word),
      .invert_i (cfg_invert),
      .win_o    (win)
   );

   cwa_detect #(.W(W), .OFFW(OFFW)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_i     (win),
      .mask_i    (cfg_mask),
      .comma_a_i (cfg_comma_a),
      .comma_b_i (cfg_comma_b),
      .cand_o    (cand),
      .hit_o     (hit),
      .found_o   (found),
      .pos_o     (pos)
   );

   cwa_ctrl #(.W(W), .OFFW(OFFW), .HOLDOFF(HOLDOFF)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_i      (ctl),
      .found_i    (found),
      .pos_i      (pos),
      .off_o      (align_offset),
      .off_next_o (off_next),
      .aligned_o  (aligned)
   );

   cwa_frame #(.W(W), .OFFW(OFFW)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand_i   (cand),
      .sel_i    (off_next),
      .bypass_i (cfg_bypass),
      .word_o   (frame_word)
   );

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (frame_word == '0 && align_offset == '0 && !aligned));

endmodule

// File: tb/comma_word_aligner_tb.sv
`timescale 1ns/1ps
module comma_word_aligner_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] raw_word = '0;
   logic       cfg_slip = 1'b0, cfg_continuous = 1'b0, cfg_bypass = 1'b0, cfg_invert = 1'b0;
   logic [9:0] cfg_mask = 10'h3FF, cfg_comma_a = 10'h183, cfg_comma_b = 10'h27C;
   logic [9:0] frame_word;
   logic [3:0] align_offset;
   logic       aligned;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   logic [9:0] m_cur, m_prev, m_dout;
   int         m_off, m_hold;
   bit         m_lock, m_pend, m_al;

   always #4 clk = ~clk;

   comma_word_aligner u_dut (
      .clk(clk), .rst_n(rst_n), .raw_word(raw_word),
      .cfg_slip(cfg_slip), .cfg_continuous(cfg_continuous),
      .cfg_bypass(cfg_bypass), .cfg_invert(cfg_invert),
      .cfg_mask(cfg_mask), .cfg_comma_a(cfg_comma_a), .cfg_comma_b(cfg_comma_b),
      .frame_word(frame_word), .align_offset(align_offset), .aligned(aligned)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [9:0] rotl10(logic [9:0] x, int k);
      logic [9:0] r;
      for (int i = 0; i < 10; i++) r[(i + k) % 10] = x[i];
      return r;
   endfunction

   task automatic model_reset();
      m_cur = '0; m_prev = '0; m_dout = '0;
      m_off = 0; m_hold = 0; m_lock = 0; m_pend = 0; m_al = 0;
   endtask

   task automatic model_edge();
      logic [19:0] w;
      logic [9:0]  g;
      int pos, n_off, n_hold;
      bit n_lock, n_pend, n_al;
      w = {m_cur, m_prev};
      pos = -1;
      for (int k = 0; k < 10; k++) begin
         g = 10'((w >> k) & 20'h3FF);
         if (pos < 0 && ((((g ^ cfg_comma_a) & cfg_mask) == 0) ||
                         (((g ^ cfg_comma_b) & cfg_mask) == 0))) pos = k;
      end
      n_off = m_off; n_lock = m_lock; n_pend = 0;
      n_hold = (m_hold > 0) ? m_hold - 1 : 0;
      n_al = m_al | m_pend;
      if (cfg_bypass) n_al = 0;
      else if (m_hold == 0 && pos >= 0 && (!m_lock || (cfg_continuous && pos != m_off))) begin
         n_al = 0;
         if (cfg_slip && pos != m_off) begin
            n_off = (m_off + 1) % 10; n_lock = 0; n_hold = 4;
         end else begin
            n_off = pos; n_lock = 1; n_pend = 1;
         end
      end
      m_dout = cfg_bypass ? w[9:0] : 10'((w >> n_off) & 20'h3FF);
      m_prev = m_cur;
      m_cur  = raw_word ^ {10{cfg_invert}};
      m_off = n_off; m_hold = n_hold; m_lock = n_lock; m_pend = n_pend; m_al = n_al;
   endtask

   // one clock: model follows the edge, outputs compared at the falling edge
   task automatic tick();
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
      chk("R4 frame_word", int'(frame_word), int'(m_dout));
      chk("R4 align_offset", int'(align_offset), m_off);
      chk("R8 aligned", int'(aligned), int'(m_al));
   endtask

   task automatic feed(logic [9:0] w);
      raw_word = w;
      tick();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      tick();
      tick();
      rst_n = 1'b1;
   endtask

   task automatic set_cfg(bit slip, bit cont, bit inv, logic [9:0] mk, logic [9:0] a, logic [9:0] b);
      cfg_slip = slip; cfg_continuous = cont; cfg_invert = inv; cfg_bypass = 0;
      cfg_mask = mk; cfg_comma_a = a; cfg_comma_b = b;
   endtask

   // place comma c at window offset k between a zero background
   task automatic inject(logic [9:0] c, int k, logic [9:0] bg);
      logic [19:0] pair;
      pair = 20'(c) << k;
      repeat (3) feed(bg);
      feed(pair[9:0] ^ bg);
      feed(pair[19:10] ^ bg);
      feed(bg);
   endtask

   initial begin
      int n;
      logic [9:0] rs;
      model_reset();
      @(negedge clk);
      // R1: outputs cleared under reset
      rst_n = 1'b0;
      tick();
      chk("R1 frame_word", int'(frame_word), 0);
      chk("R1 align_offset", int'(align_offset), 0);
      chk("R1 aligned", int'(aligned), 0);

      // R2 / R4 / R8: masked-out bit ignored, barrel jump and aligned timing
      set_cfg(0, 0, 0, 10'h3FE, 10'h183, 10'h27C);
      do_reset();
      inject(10'h182, 4, 10'h000);
      chk("R2 offset with bit0 masked", int'(align_offset), 4);
      chk("R4 framed comma", int'(frame_word), 10'h182);
      chk("R8 aligned not yet", int'(aligned), 0);
      feed(10'h000);
      chk("R8 aligned one edge later", int'(aligned), 1);

      // R2: same word with full mask is not a comma
      set_cfg(0, 0, 0, 10'h3FF, 10'h183, 10'h27C);
      do_reset();
      inject(10'h182, 4, 10'h000);
      repeat (3) feed(10'h000);
      chk("R2 no match under full mask", int'(align_offset), 0);
      chk("R2 aligned stays low", int'(aligned), 0);

      // R3: overlapping matches at offsets 1 and 5, lowest wins
      set_cfg(0, 0, 0, 10'h00F, 10'h003, 10'h003);
      do_reset();
      repeat (3) feed(10'h000);
      feed(10'h066);
      feed(10'h000);
      feed(10'h000);
      chk("R3 lowest offset", int'(align_offset), 1);

      // R10: inverted comma B at offset 7
      set_cfg(0, 0, 1, 10'h3FF, 10'h183, 10'h27C);
      do_reset();
      inject(10'h27C, 7, 10'h3FF);
      chk("R10 offset from inverted stream", int'(align_offset), 7);
      chk("R10 comma in true polarity", int'(frame_word), 10'h27C);

      // R5: bit-slip steps and holdoff gap, then lock at 3
      set_cfg(1, 0, 0, 10'h3FF, 10'h183, 10'h27C);
      do_reset();
      rs = rotl10(10'h183, 3);
      n = 0;
      while (align_offset == 0 && n < 20) begin feed(rs); n++; end
      chk("R5 first slip to 1", int'(align_offset), 1);
      n = 0;
      while (align_offset == 1 && n < 20) begin feed(rs); n++; end
      chk("R5 holdoff gap edges", n, 5);
      chk("R5 second slip to 2", int'(align_offset), 2);
      repeat (20) feed(rs);
      chk("R5 locked offset", int'(align_offset), 3);
      chk("R5 aligned after lock", int'(aligned), 1);

      // R6: one-shot ignores a comma at a new offset
      repeat (30) feed(rotl10(10'h183, 6));
      chk("R6 offset held", int'(align_offset), 3);
      chk("R6 aligned held", int'(aligned), 1);

      // R7: continuous barrel follows the comma
      set_cfg(0, 1, 0, 10'h3FF, 10'h183, 10'h27C);
      do_reset();
      repeat (6) feed(rotl10(10'h183, 3));
      chk("R7 first offset", int'(align_offset), 3);
      repeat (6) feed(rotl10(10'h183, 6));
      chk("R7 realigned offset", int'(align_offset), 6);
      chk("R7 aligned again", int'(aligned), 1);

      // R9: bypass passes words unshifted, holds offset, drops aligned
      cfg_bypass = 1'b1;
      feed(10'h155);
      chk("R9 aligned low", int'(aligned), 0);
      feed(10'h2AA);
      feed(10'h0F0);
      chk("R9 raw word out", int'(frame_word), 10'h155);
      chk("R9 offset held", int'(align_offset), 6);
      feed(10'h000);
      chk("R9 next raw word", int'(frame_word), 10'h2AA);
      cfg_bypass = 1'b0;

      // constrained random segments, checked against the reference each cycle
      void'($urandom(32'd20240611));
      for (int seg = 0; seg < 8; seg++) begin
         int k;
         logic [9:0] cw;
         set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 (seg % 3 == 2) ? 10'($urandom) | 10'h3F0 : 10'h3FF, 10'h183, 10'h27C);
         do_reset();
         k  = $urandom_range(0, 9);
         cw = rotl10(($urandom_range(0, 1) == 1) ? 10'h183 : 10'h27C, k);
         for (int c = 0; c < 400; c++) begin
            if (c % 97 == 50) k = $urandom_range(0, 9);
            cw = rotl10(10'h183, k);
            cfg_bypass = ($urandom_range(0, 49) == 0);
            if ($urandom_range(0, 2) == 0) feed(10'($urandom));
            else feed(cw ^ {10{cfg_invert}});
         end
         cfg_bypass = 1'b0;
      end

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule